// File: doc/BRIEF.md
# Erasable One-Time-Write Memory Emulator

This block is a synthesizable stand-in for a 4K x 8 ultraviolet-erasable read-only memory, sitting behind a parallel bus: a 12-bit word address, an active-low chip select, an active-low output enable, and an 8-bit data path. A separate input flag, `vpp_hi`, stands for the high programming voltage that the real part receives on its shared output-enable pin. From these four controls the block decides whether to drive a stored word, float the bus, accept a program pulse, or ignore the pins.

Writing is one-way. A program pulse can only turn ones into zeros. It is committed only when chip select is held low, with the programming flag present, for a number of clock cycles inside a parameterised window. The defaults are 45 to 55 cycles, one cycle standing for one millisecond of the nominal 50 ms pulse. Address and data are captured on the falling edge of the pulse and must stay unchanged until its end.

A blank state with every bit at 1 is restored by an erase walk. The walk writes one word per cycle and flags itself busy while it runs. The same walk starts on its own whenever reset is asserted. The data bus is modelled as a separate input and output, with `data_oe` marking the cycles in which the block would drive the pins.

Top module: `erom_emu`

## Requirements
- R1: With chip select low, output enable low, no programming flag and no erase running, the block shows the stored word at the sampled address on `data_out` one clock later, with `data_oe` high.
- R2: With the programming flag low and either chip select or output enable high, `data_oe` is 0 one clock later, and `data_out` is 0 whenever `data_oe` is 0.
- R3: Whenever `vpp_hi` was sampled high, `data_oe` is 0 in the following cycle. This covers both program mode and inhibit.
- R4: With `vpp_hi` high and chip select held high, activity on address and data leaves every stored word unchanged and does not set `pulse_err`.
- R5: A qualified pulse replaces the addressed word with the bitwise AND of the old word and the captured data. A 1 can never be restored by programming.
- R6: A pulse of fewer than PULSE_MIN or more than PULSE_MAX low cycles leaves the array unchanged and sets `pulse_err`. The pulse length is the number of rising clock edges at which chip select is sampled low with `vpp_hi` high.
- R7: If the address or data changes while a pulse is active, or `vpp_hi` drops, that pulse is discarded and `pulse_err` is set.
- R8: `pulse_err` stays at 1 until reset, through any later good pulses.
- R9: A request on `erase_req` while idle raises `erase_busy` for exactly 2^ADDR_W cycles. Afterwards every word reads 0xFF. While `erase_busy` was high in the previous cycle, `data_oe` is 0.
- R10: During reset, `erase_busy` is 1 and both `pulse_err` and `data_oe` are 0. After reset the blank walk completes and every word reads 0xFF.
- R11: An erase request aborts any pulse in progress without an error. This holds also when the request falls in the same cycle as the pulse end, and no commit ever coincides with a running erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; starts a blank walk |
| addr | input | 12 | Word address |
| ce_n | input | 1 | Chip select, active low; also the program pulse |
| oe_n | input | 1 | Output enable, active low |
| vpp_hi | input | 1 | Programming voltage present |
| data_in | input | 8 | Data presented for programming |
| data_out | output | 8 | Word driven on the bus (0 when not driving) |
| data_oe | output | 1 | High when the bus is driven |
| erase_req | input | 1 | Request a full blank walk |
| erase_busy | output | 1 | Blank walk in progress |
| pulse_err | output | 1 | Sticky flag for a rejected pulse |

## Verification
The collision of interest is the end of a program pulse landing in the same cycle as a new erase request. Both would write the array at nearly the same edge.

The bench provokes this by raising `erase_req` at exactly the cycle where chip select returns high after a correctly sized pulse. It also sends a request in the middle of a pulse. In both cases the verdict is that the addressed word reads 0xFF once the walk ends and `pulse_err` stays clear. The checker separately confirms that a commit never shares a cycle with a busy walk.

// File: rtl/erom_pkg.sv
package erom_pkg;
   typedef enum logic [2:0] {
      MODE_STANDBY,
      MODE_OUT_OFF,
      MODE_READ,
      MODE_PROGRAM,
      MODE_INHIBIT
   } erom_mode_e;
endpackage

// File: rtl/erom_mode_dec.sv
module erom_mode_dec
   import erom_pkg::*;
(
   input  logic       ce_n,
   input  logic       oe_n,
   input  logic       vpp_hi,
   output erom_mode_e mode
);
   always_comb begin
      if (vpp_hi) begin
         mode = ce_n ? MODE_INHIBIT : MODE_PROGRAM;
      end else if (ce_n) begin
         mode = MODE_STANDBY;
      end else if (oe_n) begin
         mode = MODE_OUT_OFF;
      end else begin
         mode = MODE_READ;
      end
   end
endmodule

// File: rtl/erom_pulse_qual.sv
module erom_pulse_qual
   import erom_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 8,
   parameter int PULSE_MIN = 45,
   parameter int PULSE_MAX = 55
) (
   input  logic              clk,
   input  logic              rst_n,
   input  erom_mode_e        mode,
   input  logic              ce_n,
   input  logic              vpp_hi,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data_in,
   input  logic              abort,
   output logic              commit,
   output logic [ADDR_W-1:0] commit_addr,
   output logic [DATA_W-1:0] commit_data,
   output logic              err_evt
);
   localparam int CNT_W = $clog2(PULSE_MAX + 2);
   localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(PULSE_MAX + 1);
   localparam logic [CNT_W-1:0] CNT_LO  = CNT_W'(PULSE_MIN);
   localparam logic [CNT_W-1:0] CNT_HI  = CNT_W'(PULSE_MAX);

   logic              ce_n_q;
   logic              active_q;
   logic              bad_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] cap_addr_q;
   logic [DATA_W-1:0] cap_data_q;
   logic              commit_q;
   logic              err_q;
   logic              start;

   assign start = (mode == MODE_PROGRAM) && ce_n_q && !abort;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_n_q     <= 1'b1;
         active_q   <= 1'b0;
         bad_q      <= 1'b0;
         cnt_q      <= '0;
         cap_addr_q <= '0;
         cap_data_q <= '0;
         commit_q   <= 1'b0;
         err_q      <= 1'b0;
      end else begin
         ce_n_q   <= ce_n;
         commit_q <= 1'b0;
         err_q    <= 1'b0;
         if (abort) begin
            active_q <= 1'b0;
         end else if (active_q) begin
            if (ce_n) begin
               active_q <= 1'b0;
               if (!bad_q && cnt_q >= CNT_LO && cnt_q <= CNT_HI) begin
                  commit_q <= 1'b1;
               end else begin
                  err_q <= 1'b1;
               end
            end else begin
               if (cnt_q != CNT_SAT) begin
                  cnt_q <= cnt_q + 1'b1;
               end
               if (addr != cap_addr_q || data_in != cap_data_q || !vpp_hi) begin
                  bad_q <= 1'b1;
               end
            end
         end else if (start) begin
            active_q   <= 1'b1;
            bad_q      <= 1'b0;
            cnt_q      <= CNT_W'(1);
            cap_addr_q <= addr;
            cap_data_q <= data_in;
         end
      end
   end

   assign commit      = commit_q;
   assign commit_addr = cap_addr_q;
   assign commit_data = cap_data_q;
   assign err_evt     = err_q;
endmodule

// File: rtl/erom_array.sv
module erom_array #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              erase_req,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

   logic [DATA_W-1:0] mem [DEPTH];
   logic              busy_q;
   logic [ADDR_W-1:0] ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b1;
         ptr_q  <= '0;
      end else if (busy_q) begin
         ptr_q <= ptr_q + 1'b1;
         if (ptr_q == LAST) begin
            busy_q <= 1'b0;
         end
      end else if (erase_req) begin
         busy_q <= 1'b1;
         ptr_q  <= '0;
      end
   end

   always_ff @(posedge clk) begin
      if (busy_q) begin
         mem[ptr_q] <= '1;
      end else if (wr_en) begin
         mem[wr_addr] <= mem[wr_addr] & wr_data;
      end
   end

   assign rd_data = mem[rd_addr];
   assign busy    = busy_q;
endmodule

// File: rtl/erom_emu.sv
module erom_emu
   import erom_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 8,
   parameter int PULSE_MIN = 45,
   parameter int PULSE_MAX = 55
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              vpp_hi,
   input  logic [DATA_W-1:0] data_in,
   output logic [DATA_W-1:0] data_out,
   output logic              data_oe,
   input  logic              erase_req,
   output logic              erase_busy,
   output logic              pulse_err
);
   generate
      if (PULSE_MIN < 1) begin : g_bad_min
         $error("PULSE_MIN must be at least 1");
      end
      if (PULSE_MAX < PULSE_MIN) begin : g_bad_max
         $error("PULSE_MAX must not be below PULSE_MIN");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_w
         $error("ADDR_W and DATA_W must be positive");
      end
   endgenerate

   erom_mode_e        mode;
   logic              abort;
   logic              commit_w;
   logic [ADDR_W-1:0] commit_addr_w;
   logic [DATA_W-1:0] commit_data_w;
   logic              err_evt_w;
   logic [DATA_W-1:0] rd_data_w;
   logic              busy_w;
   logic              drive_now;
   logic              err_q;
   logic              oe_q;
   logic [DATA_W-1:0] dout_q;

   erom_mode_dec u_dec (
      .ce_n   (ce_n),
      .oe_n   (oe_n),
      .vpp_hi (vpp_hi),
      .mode   (mode)
   );

   assign abort = erase_req || busy_w;

   erom_pulse_qual #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .PULSE_MIN (PULSE_MIN),
      .PULSE_MAX (PULSE_MAX)
   ) u_qual (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode        (mode),
      .ce_n        (ce_n),
      .vpp_hi      (vpp_hi),
      .addr        (addr),
      .data_in     (data_in),
      .abort       (abort),
      .commit      (commit_w),
      .commit_addr (commit_addr_w),
      .commit_data (commit_data_w),
      .err_evt     (err_evt_w)
   );

   erom_array #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .erase_req (erase_req),
      .wr_en     (commit_w),
      .wr_addr   (commit_addr_w),
      .wr_data   (commit_data_w),
      .rd_addr   (addr),
      .rd_data   (rd_data_w),
      .busy      (busy_w)
   );

   assign drive_now = (mode == MODE_READ) && !busy_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q  <= 1'b0;
         oe_q   <= 1'b0;
         dout_q <= '0;
      end else begin
         if (err_evt_w) begin
            err_q <= 1'b1;
         end
         oe_q   <= drive_now;
         dout_q <= drive_now ? rd_data_w : '0;
      end
   end

   assign data_out   = dout_q;
   assign data_oe    = oe_q;
   assign erase_busy = busy_w;
   assign pulse_err  = err_q;
endmodule

// File: rtl/erom_emu_chk.sv
module erom_emu_chk (
   input logic clk,
   input logic rst_n,
   input logic ce_n,
   input logic oe_n,
   input logic vpp_hi,
   input logic data_oe,
   input logic erase_busy,
   input logic pulse_err,
   input logic commit
);
   assert_read_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe |-> $past(!ce_n && !oe_n && !vpp_hi && !erase_busy));

   assert_vpp_float_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(vpp_hi) |-> !data_oe);

   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_err |=> pulse_err);

   assert_busy_float_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(erase_busy) |-> !data_oe);

   assert_no_commit_in_erase_R11: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> !erase_busy);
endmodule

bind erom_emu erom_emu_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ce_n       (ce_n),
   .oe_n       (oe_n),
   .vpp_hi     (vpp_hi),
   .data_oe    (data_oe),
   .erase_busy (erase_busy),
   .pulse_err  (pulse_err),
   .commit     (commit_w)
);

// File: tb/erom_emu_tb_top.sv
module erom_emu_tb_top;
   localparam int DEPTH = 4096;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] addr = '0;
   logic        ce_n = 1'b1;
   logic        oe_n = 1'b1;
   logic        vpp_hi = 1'b0;
   logic [7:0]  data_in = '0;
   logic [7:0]  data_out;
   logic        data_oe;
   logic        erase_req = 1'b0;
   logic        erase_busy;
   logic        pulse_err;

   int n_chk = 0;
   int n_bad = 0;
   logic oe_seen;

   always #5 clk = ~clk;

   erom_emu dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr       (addr),
      .ce_n       (ce_n),
      .oe_n       (oe_n),
      .vpp_hi     (vpp_hi),
      .data_in    (data_in),
      .data_out   (data_out),
      .data_oe    (data_oe),
      .erase_req  (erase_req),
      .erase_busy (erase_busy),
      .pulse_err  (pulse_err)
   );

   // {addr, data, pulse length, expected word, expected error flag}
   localparam logic [36:0] VEC [6] = '{
      {12'h000, 8'hA5, 8'd50, 8'hA5, 1'b0},
      {12'h000, 8'h0F, 8'd45, 8'h05, 1'b0},
      {12'hFFF, 8'h3C, 8'd55, 8'h3C, 1'b0},
      {12'h123, 8'h00, 8'd44, 8'hFF, 1'b1},
      {12'h456, 8'h7E, 8'd56, 8'hFF, 1'b1},
      {12'h123, 8'h7E, 8'd50, 8'h7E, 1'b1}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   task automatic wait_idle();
      int guard = 0;
      while (erase_busy && guard < 10000) begin
         @(negedge clk);
         guard++;
      end
   endtask

   task automatic read_word(input logic [11:0] a, output logic [7:0] d, output logic oe);
      @(negedge clk);
      vpp_hi = 1'b0; ce_n = 1'b0; oe_n = 1'b0; addr = a;
      @(negedge clk);
      d = data_out; oe = data_oe;
      ce_n = 1'b1; oe_n = 1'b1;
   endtask

   // kind: 0 clean, 1 address moves mid pulse, 2 erase mid pulse, 3 erase at pulse end
   task automatic pulse(input logic [11:0] a, input logic [7:0] d, input int len, input int kind);
      @(negedge clk);
      oe_n = 1'b1; vpp_hi = 1'b1; addr = a; data_in = d; ce_n = 1'b1;
      @(negedge clk);
      ce_n = 1'b0;
      oe_seen = 1'b0;
      for (int k = 0; k < len; k++) begin
         @(negedge clk);
         oe_seen = oe_seen | data_oe;
         erase_req = 1'b0;
         if (k == len / 2 && kind == 1) addr = a ^ 12'h001;
         if (k == len / 2 && kind == 2) erase_req = 1'b1;
      end
      ce_n = 1'b1;
      if (kind == 3) erase_req = 1'b1;
      @(negedge clk);
      erase_req = 1'b0;
      @(negedge clk);
      @(negedge clk);
      vpp_hi = 1'b0;
      addr = a;
      wait_idle();
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R10 busy in reset", {31'd0, erase_busy}, 32'd1);
      check("R10 err in reset", {31'd0, pulse_err}, 32'd0);
      check("R10 oe in reset", {31'd0, data_oe}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      wait_idle();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] d;
      logic       oe;
      int         cnt;

      do_reset();
      read_word(12'h7AB, d, oe);
      check("R10 blank after reset", {24'd0, d}, 32'hFF);
      check("R1 read drives", {31'd0, oe}, 32'd1);

      // table walk: R5 (AND commit), R6 (window), R8 (sticky)
      for (int i = 0; i < 6; i++) begin
         pulse(VEC[i][36:25], VEC[i][24:17], int'(VEC[i][16:9]), 0);
         read_word(VEC[i][36:25], d, oe);
         check("R5/R6 word after pulse", {24'd0, d}, {24'd0, VEC[i][8:1]});
         check("R6/R8 error flag", {31'd0, pulse_err}, {31'd0, VEC[i][0]});
      end

      do_reset();
      // R2 standby and output-disable
      @(negedge clk); ce_n = 1'b1; oe_n = 1'b0; vpp_hi = 1'b0;
      @(negedge clk);
      check("R2 standby floats", {31'd0, data_oe}, 32'd0);
      check("R2 float value", {24'd0, data_out}, 32'd0);
      ce_n = 1'b0; oe_n = 1'b1;
      @(negedge clk);
      check("R2 output disable floats", {31'd0, data_oe}, 32'd0);
      ce_n = 1'b1;

      // R1/R5 program then verify, then try to set bits back
      pulse(12'h010, 8'hC3, 50, 0);
      check("R3 floats during program", {31'd0, oe_seen}, 32'd0);
      read_word(12'h010, d, oe);
      check("R1 verify data", {24'd0, d}, 32'hC3);
      check("R1 verify drives", {31'd0, oe}, 32'd1);
      pulse(12'h010, 8'hFF, 50, 0);
      read_word(12'h010, d, oe);
      check("R5 ones not restored", {24'd0, d}, 32'hC3);

      // R4 inhibit: vpp high, chip select high, busy pins
      @(negedge clk); vpp_hi = 1'b1; ce_n = 1'b1; oe_n = 1'b0;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         addr = 12'h010 + 12'(k); data_in = 8'(k);
         if (k == 2) check("R3 inhibit floats", {31'd0, data_oe}, 32'd0);
      end
      @(negedge clk); vpp_hi = 1'b0;
      read_word(12'h010, d, oe);
      check("R4 inhibit keeps word", {24'd0, d}, 32'hC3);
      check("R4 inhibit no error", {31'd0, pulse_err}, 32'd0);

      // R7 address moves during pulse
      pulse(12'h020, 8'h00, 50, 1);
      read_word(12'h020, d, oe);
      check("R7 moved pulse ignored", {24'd0, d}, 32'hFF);
      check("R7 moved pulse flags", {31'd0, pulse_err}, 32'd1);
      pulse(12'h030, 8'h0F, 50, 0);
      read_word(12'h030, d, oe);
      check("R8 good pulse after error commits", {24'd0, d}, 32'h0F);
      check("R8 flag stays", {31'd0, pulse_err}, 32'd1);

      do_reset();
      // R11 erase in the middle of a pulse
      pulse(12'h040, 8'h00, 50, 2);
      read_word(12'h040, d, oe);
      check("R11 mid-pulse erase wins", {24'd0, d}, 32'hFF);
      check("R11 no error on abort", {31'd0, pulse_err}, 32'd0);
      // R11 erase in the same cycle as pulse end
      pulse(12'h050, 8'h00, 50, 3);
      read_word(12'h050, d, oe);
      check("R11 same-cycle erase wins", {24'd0, d}, 32'hFF);
      check("R11 no error on collision", {31'd0, pulse_err}, 32'd0);

      // R9 explicit erase, duration and floating bus
      pulse(12'h060, 8'h00, 50, 0);
      read_word(12'h060, d, oe);
      check("R9 word programmed before erase", {24'd0, d}, 32'h00);
      @(negedge clk); erase_req = 1'b1;
      @(negedge clk); erase_req = 1'b0; ce_n = 1'b0; oe_n = 1'b0; addr = 12'h060;
      cnt = 0;
      while (erase_busy && cnt < 10000) begin
         cnt++;
         if (cnt == 3) check("R9 floats while busy", {31'd0, data_oe}, 32'd0);
         @(negedge clk);
      end
      ce_n = 1'b1; oe_n = 1'b1;
      check("R9 busy length", cnt, DEPTH);
      read_word(12'h060, d, oe);
      check("R9 blank after erase", {24'd0, d}, 32'hFF);

      summary();
      $finish;
   end
endmodule